// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from the moment a fault or an interrupt is recognised to the moment the fetch of the first handler instruction is issued. It chooses one pending request and works out the new status word. It finds the vector number, pushes a two-word frame onto the single system stack and reads the handler address from the vector table. At the end it hands the core a new status word, a new stack pointer and a fetch address.

A fault takes its vector number from its type code. An interrupt takes its vector number from an acknowledge read on the bus. The acknowledge read uses a dedicated address range, and the request level is folded into the address. The core uses one stack pointer for all modes. Before the push the pointer is rounded down to a word boundary, and the amount removed is stored in the frame. Every exception kind uses the same frame layout.

All memory traffic goes through a simple bus-master port. The port holds a request until it is acknowledged. A request that arrives while a sequence is in progress is not taken.

Top module: `exc_entry_seq`

## Requirements
- R1: After synchronous reset, `busy`, `bus_req` and `fetch_valid` are 0, and `sr_out` and `sp_out` are 0.
- R2: For every exception, the new status word equals the status word sampled at acceptance, with bit 13 (supervisor) set and bit 15 (trace) cleared. All other bits are kept unchanged for a fault.
- R3: For an interrupt, the new status word also has bit 12 (master) cleared, and bits 10:8 (priority mask) set to the serviced level.
- R4: A fault's vector number is its 4-bit type code plus 2, as an 8-bit value.
- R5: An interrupt at `irq_level` L is taken only when L is greater than `sr_in[10:8]`, or when L is 7. Level 0 means no request. A request that is not taken starts no bus activity.
- R6: When a fault and an eligible interrupt are present in the same idle cycle, the fault is serviced first. An interrupt that is still held is serviced after the fault sequence ends.
- R7: An interrupt first runs a read with `bus_iack`=1 at address 0xFFFF_FFE0 OR (L<<2). The vector number is `bus_rdata[7:0]` of that read.
- R8: Let A = `sp_in` with bits 1:0 cleared. The saved PC is written first, at A-4. The format word is written second, at A-8. `sp_out` becomes A-8.
- R9: The format word holds, from the top bit down: bits 31:30 = 01, bits 29:28 = `sp_in[1:0]`, bits 25:18 = vector number, and bits 15:0 = the saved status word. All other bits are 0.
- R10: The handler address is read from ({`vbr_in`[31:20], 20'h0} + 4 × vector). The low 20 bits of `vbr_in` are ignored. The value read appears on `fetch_addr` with a one-cycle `fetch_valid` pulse, together with the new `sr_out` and `sp_out`.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged on the next cycle.
- R12: Requests presented while `busy` is high are ignored. A fault pulsed during a sequence changes neither that sequence's frame nor any later bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_req | input | 1 | Fault request, sampled while idle |
| fault_type | input | 4 | Fault type code |
| irq_level | input | 3 | Pending interrupt level, 0 = none |
| sr_in | input | 16 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| pc_in | input | 32 | Program counter to save |
| vbr_in | input | 32 | Vector table base |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_iack | output | 1 | Cycle targets the acknowledge space |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle completion of the current cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| sr_out | output | 16 | New status word |
| sp_out | output | 32 | New stack pointer |
| fetch_addr | output | 32 | First handler instruction address |
| fetch_valid | output | 1 | One-cycle pulse: handler fetch issued |
| busy | output | 1 | Sequence in progress |

## Verification
A fault and an interrupt can both claim the idle slot in one cycle. The bench pulses a fault while it already holds an interrupt level above the mask. It then reads the bus log. The log must show a fault frame with the fault-derived vector, then an acknowledge read, then an interrupt frame carrying the acknowledged vector. A fault pulse that lands mid-sequence is also checked. It must leave the running frame untouched and start no second sequence.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int SR_W   = 16;
    localparam int LVL_W  = 3;
    localparam int TYPE_W = 4;
    localparam int VEC_W  = 8;
    localparam int ADDR_W = 32;

    localparam int SR_TRACE = 15;
    localparam int SR_SUPER = 13;
    localparam int SR_MSTR  = 12;
    localparam int SR_IPL   = 8;

    localparam int TABLE_ALIGN = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IACK,
        ST_PUSH_PC,
        ST_PUSH_FMT,
        ST_VFETCH
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_FAULT,
        SRC_IRQ
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [VEC_W-1:0]  vector;
        logic [LVL_W-1:0]  level;
    } pick_t;

    typedef struct packed {
        logic [SR_W-1:0]   saved_sr;
        logic [SR_W-1:0]   new_sr;
        logic [ADDR_W-1:0] base;
        logic [1:0]        adj;
        logic [ADDR_W-1:0] vtb;
    } ctx_t;

    function automatic logic irq_eligible(input logic [LVL_W-1:0] lvl,
                                          input logic [LVL_W-1:0] mask);
        return (lvl == '1) || (lvl > mask);
    endfunction

    function automatic logic [31:0] fmt_word(input logic [1:0] adj,
                                             input logic [VEC_W-1:0] vec,
                                             input logic [SR_W-1:0] sr);
        return {2'b01, adj, 2'b00, vec, 2'b00, sr};
    endfunction

    function automatic logic [ADDR_W-1:0] vec_addr(input logic [ADDR_W-1:0] vtb,
                                                   input logic [VEC_W-1:0] vec);
        return vtb + {{(ADDR_W-VEC_W-2){1'b0}}, vec, 2'b00};
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int VEC_OFS = 2
) (
    input  logic              fault_req,
    input  logic [TYPE_W-1:0] fault_type,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [LVL_W-1:0]  ipl_mask,
    output pick_t             pick
);

    always_comb begin
        pick        = '0;
        pick.src    = SRC_NONE;
        if (fault_req) begin
            pick.src    = SRC_FAULT;
            pick.vector = VEC_W'(fault_type) + VEC_W'(VEC_OFS);
        end else if (irq_level != '0 && irq_eligible(irq_level, ipl_mask)) begin
            pick.src   = SRC_IRQ;
            pick.level = irq_level;
        end
    end

endmodule

// File: rtl/exc_frame.sv
module exc_frame
    import exc_pkg::*;
(
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] vbr_in,
    input  logic              is_irq,
    input  logic [LVL_W-1:0]  level,
    output ctx_t              ctx
);

    localparam logic [ADDR_W-1:0] VTB_MASK = {{(ADDR_W-TABLE_ALIGN){1'b1}}, {TABLE_ALIGN{1'b0}}};

    always_comb begin
        ctx.saved_sr = sr_in;
        ctx.new_sr   = sr_in;
        ctx.new_sr[SR_SUPER] = 1'b1;
        ctx.new_sr[SR_TRACE] = 1'b0;
        if (is_irq) begin
            ctx.new_sr[SR_MSTR] = 1'b0;
            ctx.new_sr[SR_IPL +: LVL_W] = level;
        end
        ctx.adj  = sp_in[1:0];
        ctx.base = {sp_in[ADDR_W-1:2], 2'b00};
        ctx.vtb  = vbr_in & VTB_MASK;
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter logic [31:0] IACK_SPACE = 32'hFFFF_FFE0,
    parameter int          VEC_OFS    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fault_req,
    input  logic [3:0]  fault_type,
    input  logic [2:0]  irq_level,
    input  logic [15:0] sr_in,
    input  logic [31:0] sp_in,
    input  logic [31:0] pc_in,
    input  logic [31:0] vbr_in,
    output logic        bus_req,
    output logic        bus_we,
    output logic        bus_iack,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    output logic [15:0] sr_out,
    output logic [31:0] sp_out,
    output logic [31:0] fetch_addr,
    output logic        fetch_valid,
    output logic        busy
);

    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    seq_state_e        state;
    pick_t             pick;
    ctx_t              ctx, ctx_q;
    logic [ADDR_W-1:0] pc_q, sp_q, fetch_q;
    logic [VEC_W-1:0]  vec_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [SR_W-1:0]   sr_q;
    logic              fv_q;

    exc_arbiter #(.VEC_OFS(VEC_OFS)) u_arb (
        .fault_req  (fault_req),
        .fault_type (fault_type),
        .irq_level  (irq_level),
        .ipl_mask   (sr_in[SR_IPL +: LVL_W]),
        .pick       (pick)
    );

    exc_frame u_frame (
        .sr_in  (sr_in),
        .sp_in  (sp_in),
        .vbr_in (vbr_in),
        .is_irq (pick.src == SRC_IRQ),
        .level  (pick.level),
        .ctx    (ctx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctx_q   <= '0;
            pc_q    <= '0;
            vec_q   <= '0;
            lvl_q   <= '0;
            sr_q    <= '0;
            sp_q    <= '0;
            fetch_q <= '0;
            fv_q    <= 1'b0;
        end else begin
            fv_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (pick.src != SRC_NONE) begin
                        ctx_q <= ctx;
                        pc_q  <= pc_in;
                        vec_q <= pick.vector;
                        lvl_q <= pick.level;
                        state <= (pick.src == SRC_IRQ) ? ST_IACK : ST_PUSH_PC;
                    end
                end
                ST_IACK: begin
                    if (bus_ack) begin
                        vec_q <= bus_rdata[VEC_W-1:0];
                        state <= ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC: begin
                    if (bus_ack) state <= ST_PUSH_FMT;
                end
                ST_PUSH_FMT: begin
                    if (bus_ack) state <= ST_VFETCH;
                end
                ST_VFETCH: begin
                    if (bus_ack) begin
                        fetch_q <= bus_rdata;
                        sr_q    <= ctx_q.new_sr;
                        sp_q    <= ctx_q.base - 2 * WORD;
                        fv_q    <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_iack  = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state)
            ST_IACK: begin
                bus_req  = 1'b1;
                bus_iack = 1'b1;
                bus_addr = IACK_SPACE | {{(ADDR_W-LVL_W-2){1'b0}}, lvl_q, 2'b00};
            end
            ST_PUSH_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ctx_q.base - WORD;
                bus_wdata = pc_q;
            end
            ST_PUSH_FMT: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ctx_q.base - 2 * WORD;
                bus_wdata = fmt_word(ctx_q.adj, vec_q, ctx_q.saved_sr);
            end
            ST_VFETCH: begin
                bus_req  = 1'b1;
                bus_addr = vec_addr(ctx_q.vtb, vec_q);
            end
            default: ;
        endcase
    end

    assign sr_out      = sr_q;
    assign sp_out      = sp_q;
    assign fetch_addr  = fetch_q;
    assign fetch_valid = fv_q;
    assign busy        = (state != ST_IDLE);

    // R11: a pending cycle keeps its request, direction, address and data
    assert_bus_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    // R7: acknowledge cycles are always reads
    assert_iack_read_R7: assert property (@(posedge clk) disable iff (rst)
        bus_iack |-> (bus_req && !bus_we));

    // R8: the final stack pointer is word aligned
    assert_frame_align_R8: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (sp_out[1:0] == 2'b00));

    // R2: supervisor set and trace clear on completion
    assert_sr_super_R2: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (sr_out[SR_SUPER] && !sr_out[SR_TRACE]));

    // R6: an idle fault goes straight to stacking, never to acknowledge
    assert_fault_first_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && fault_req) |=> (state == ST_PUSH_PC));

    // R10: the fetch strobe lasts one cycle
    assert_fetch_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> !fetch_valid);

endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;

    localparam int RESP_LAT = 2;
    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fault_req = 1'b0;
    logic [3:0]  fault_type = '0;
    logic [2:0]  irq_level = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] sp_in = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] vbr_in = '0;
    logic        bus_req, bus_we, bus_iack;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic [15:0] sr_out;
    logic [31:0] sp_out, fetch_addr;
    logic        fetch_valid, busy;

    logic [7:0]  iack_vec = 8'h40;

    int checks = 0;
    int fails = 0;
    int resp_checks = 0;
    int resp_fails = 0;
    bit finished = 1'b0;

    logic [31:0] lg_addr [32];
    logic [31:0] lg_data [32];
    logic        lg_we   [32];
    logic        lg_iack [32];
    int          nlog = 0;

    always #2.5 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst(rst),
        .fault_req(fault_req), .fault_type(fault_type), .irq_level(irq_level),
        .sr_in(sr_in), .sp_in(sp_in), .pc_in(pc_in), .vbr_in(vbr_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_iack(bus_iack),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .sr_out(sr_out), .sp_out(sp_out), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .busy(busy)
    );

    function automatic logic [31:0] table_data(input logic [31:0] a);
        return a ^ 32'h0F0F_0000;
    endfunction

    // bus responder: acknowledges after RESP_LAT waiting cycles, logs every cycle
    int          lat = 0;
    bit          seen = 1'b0;
    logic [31:0] first_addr = '0;
    logic [31:0] first_wdata = '0;
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
            seen = 1'b0;
            lat = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
            seen = 1'b0;
            lat = 0;
        end else if (bus_req) begin
            if (!seen) begin
                seen = 1'b1;
                first_addr = bus_addr;
                first_wdata = bus_wdata;
                lat = 0;
            end
            if (lat == RESP_LAT) begin
                resp_checks++;
                if (bus_addr !== first_addr || bus_wdata !== first_wdata) begin
                    resp_fails++;
                    $display("FAIL R11 held cycle changed: addr %h data %h, expected %h %h",
                             bus_addr, bus_wdata, first_addr, first_wdata);
                end
                bus_rdata = bus_iack ? {24'h0, iack_vec} : table_data(bus_addr);
                if (nlog < 32) begin
                    lg_addr[nlog] = bus_addr;
                    lg_data[nlog] = bus_we ? bus_wdata : bus_rdata;
                    lg_we[nlog]   = bus_we;
                    lg_iack[nlog] = bus_iack;
                end
                nlog++;
                bus_ack = 1'b1;
            end else begin
                lat++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_done(input string tag);
        bit got = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (fetch_valid) begin
                got = 1'b1;
                break;
            end
        end
        chk({tag, " fetch strobe seen"}, {31'b0, got}, 32'd1);
    endtask

    function automatic logic [15:0] exp_sr(input logic [15:0] sr, input bit irq, input logic [2:0] lvl);
        logic [15:0] r = sr;
        r[13] = 1'b1;
        r[15] = 1'b0;
        if (irq) begin
            r[12] = 1'b0;
            r[10:8] = lvl;
        end
        return r;
    endfunction

    // checks one frame starting at log index b
    task automatic check_frame(input string tag, input int b, input logic [15:0] sr,
                               input logic [31:0] sp, input logic [31:0] pc,
                               input logic [7:0] vec, input logic [31:0] vbr,
                               input bit irq, input logic [2:0] lvl);
        logic [31:0] al = {sp[31:2], 2'b00};
        logic [31:0] fw = {2'b01, sp[1:0], 2'b00, vec, 2'b00, sr};
        logic [31:0] va = {vbr[31:20], 20'h0} + {22'h0, vec, 2'b00};
        chk({tag, " R8 pc push addr"}, lg_addr[b], al - 32'd4);
        chk({tag, " R8 pc push data"}, lg_data[b], pc);
        chk({tag, " R8 pc push is write"}, {31'b0, lg_we[b]}, 32'd1);
        chk({tag, " R8 fmt push addr"}, lg_addr[b+1], al - 32'd8);
        chk({tag, " R9 fmt word"}, lg_data[b+1], fw);
        chk({tag, " R10 table addr"}, lg_addr[b+2], va);
        chk({tag, " R10 table read"}, {31'b0, lg_we[b+2]}, 32'd0);
        chk({tag, " R10 fetch addr"}, fetch_addr, table_data(va));
        chk({tag, " R8 sp_out"}, sp_out, al - 32'd8);
        chk({tag, irq ? " R3 sr_out" : " R2 sr_out"}, {16'h0, sr_out}, {16'h0, exp_sr(sr, irq, lvl)});
    endtask

    task automatic pulse_fault(input logic [3:0] t);
        @(negedge clk);
        fault_type = t;
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 bus_req", {31'b0, bus_req}, 32'd0);
        chk("R1 fetch_valid", {31'b0, fetch_valid}, 32'd0);
        chk("R1 sr_out", {16'h0, sr_out}, 32'd0);
        chk("R1 sp_out", sp_out, 32'd0);
    endtask

    task automatic t_fault_aligned;
        int b = nlog;
        sr_in = 16'hA71F; sp_in = 32'h0001_0000; pc_in = 32'h0000_1234;
        vbr_in = 32'h1230_0ABC;
        pulse_fault(4'd5);
        wait_done("fault aligned");
        check_frame("fault aligned R4", b, 16'hA71F, 32'h0001_0000, 32'h0000_1234,
                    8'd7, 32'h1230_0ABC, 1'b0, 3'd0);
    endtask

    task automatic t_fault_misaligned;
        int b = nlog;
        sr_in = 16'h0000; sp_in = 32'h0002_0003; pc_in = 32'hCAFE_0000;
        vbr_in = 32'h0000_0000;
        pulse_fault(4'd15);
        wait_done("fault misaligned");
        check_frame("fault misaligned R4", b, 16'h0000, 32'h0002_0003, 32'hCAFE_0000,
                    8'd17, 32'h0, 1'b0, 3'd0);
    endtask

    task automatic t_irq;
        int b = nlog;
        sr_in = 16'h9200; sp_in = 32'h0003_0102; pc_in = 32'h0000_8888;
        vbr_in = 32'h0040_0000; iack_vec = 8'h64;
        @(negedge clk);
        irq_level = 3'd5;
        @(negedge clk);
        irq_level = 3'd0;
        wait_done("irq5");
        chk("irq5 R7 iack addr", lg_addr[b], 32'hFFFF_FFF4);
        chk("irq5 R7 iack flag", {31'b0, lg_iack[b]}, 32'd1);
        check_frame("irq5 R7", b + 1, 16'h9200, 32'h0003_0102, 32'h0000_8888,
                    8'h64, 32'h0040_0000, 1'b1, 3'd5);
    endtask

    task automatic t_irq_masked_and_nmi;
        int b = nlog;
        sr_in = 16'h2300; sp_in = 32'h0000_4000; pc_in = 32'h10; vbr_in = 32'h0;
        @(negedge clk);
        irq_level = 3'd3;
        repeat (8) @(negedge clk);
        chk("R5 masked level stays idle", {31'b0, busy}, 32'd0);
        chk("R5 masked level no bus", nlog, b);
        irq_level = 3'd0;
        sr_in = 16'h2700; iack_vec = 8'h99;
        @(negedge clk);
        irq_level = 3'd7;
        @(negedge clk);
        irq_level = 3'd0;
        wait_done("irq7");
        chk("irq7 R5 iack addr", lg_addr[b], 32'hFFFF_FFFC);
        check_frame("irq7 R5", b + 1, 16'h2700, 32'h0000_4000, 32'h10,
                    8'h99, 32'h0, 1'b1, 3'd7);
    endtask

    task automatic t_collision;
        int b = nlog;
        sr_in = 16'h2000; sp_in = 32'h0005_0000; pc_in = 32'h0000_0A00;
        vbr_in = 32'h0; iack_vec = 8'h50;
        @(negedge clk);
        irq_level = 3'd4;
        fault_type = 4'd1;
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        wait_done("collision fault");
        check_frame("collision R6 fault", b, 16'h2000, 32'h0005_0000, 32'h0A00,
                    8'd3, 32'h0, 1'b0, 3'd0);
        chk("collision R6 fault no iack", {31'b0, lg_iack[b]}, 32'd0);
        @(negedge clk);
        irq_level = 3'd0;
        wait_done("collision irq");
        chk("collision R6 iack after fault", {31'b0, lg_iack[b+3]}, 32'd1);
        check_frame("collision R6 irq", b + 4, 16'h2000, 32'h0005_0000, 32'h0A00,
                    8'h50, 32'h0, 1'b1, 3'd4);
    endtask

    task automatic t_busy_ignore;
        int b = nlog;
        sr_in = 16'h0400; sp_in = 32'h0006_0001; pc_in = 32'h0000_0C00; vbr_in = 32'h0;
        pulse_fault(4'd1);
        @(negedge clk);
        fault_type = 4'd9;
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        wait_done("busy ignore");
        check_frame("R12 running frame", b, 16'h0400, 32'h0006_0001, 32'h0C00,
                    8'd3, 32'h0, 1'b0, 3'd0);
        repeat (6) @(negedge clk);
        chk("R12 no second sequence busy", {31'b0, busy}, 32'd0);
        chk("R12 no second sequence bus", nlog, b + 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fault_aligned();
        t_fault_misaligned();
        t_irq();
        t_irq_masked_and_nmi();
        t_collision();
        t_busy_ignore();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==",
                 checks + resp_checks, fails + resp_fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==",
                     checks + resp_checks + 1, fails + resp_fails + 1);
            $finish;
        end
    end

endmodule